// File: doc/BRIEF.md
# Hold and External Trigger Sequencer

This block decides when a free-running measurement engine may take a reading. In the free-run state, with the hold request released, the sample-enable output stays high and the engine measures continuously. When the active-low hold request is driven low, internal sampling stops and the sample-enable output goes low. From then on, readings come only from external trigger pulses.

A trigger is accepted only after it has been seen low for a minimum number of clock cycles. The input first passes through two synchroniser flops. An accepted trigger in hold arms the block, and the sample-enable output goes high. The next rising edge of the engine's measure/zero phase signal starts exactly one reading. The falling edge of that phase signal that ends the reading disarms the block, and the sample-enable output drops until the next trigger. Falling phase edges seen while the block is armed but before the reading starts are ignored.

Top module: `hold_trig_seq`

## Requirements
- R1: While `rst_n` is low, `sample_en` is high and no reading is armed.
- R2: A high `hold_n` sampled on a rising clock edge makes `sample_en` high after that edge, whatever `mz` and `trig_n` do. Releasing hold therefore restores continuous sampling one clock later.
- R3: A low `hold_n` sampled on a rising edge, with no reading armed, makes `sample_en` low after that edge. While no trigger is accepted it stays low, and edges of `mz` in either direction have no effect on it.
- R4: In hold, a trigger is accepted only if `trig_n` is sampled low on `TRIG_MIN_CYCLES` consecutive rising edges (the default of 250000 equals 1 ms at 250 MHz). `sample_en` then goes high after the edge `TRIG_MIN_CYCLES`+1 edges after the first low sample. A pulse one cycle shorter is ignored.
- R5: While armed, a falling edge of `mz` (high on one sampled edge, low on the next) leaves `sample_en` high. The next rising edge of `mz` starts the reading, and `sample_en` stays high.
- R6: The falling edge of `mz` that ends the reading makes `sample_en` low after the edge on which `mz` is first sampled low.
- R7: One trigger pulse gives at most one reading. A pulse held low past the end of its reading is not accepted again until `trig_n` has returned high.
- R8: A trigger that completes while a reading is armed or running is ignored, so `sample_en` still drops at the end of that reading.
- R9: A trigger that completes while hold is released is ignored. After hold is entered, `sample_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_n | input | 1 | Active-low hold request (low = hold, readings only on trigger) |
| trig_n | input | 1 | Active-low external trigger, asynchronous to `clk` |
| mz | input | 1 | Measure/zero phase from the engine, synchronous to `clk` |
| sample_en | output | 1 | High when the engine may sample |

## Verification
The sequencer is exercised in free run with `mz` toggling, which must never drop `sample_en`, and in hold with `mz` toggling and no trigger, which must never raise it. Two trigger pulses, one of exactly the minimum width and one a cycle shorter, separate a correct width threshold from an off-by-one in either direction. A falling `mz` edge before the reading, and another at its end, check that only the reading's own falling edge disarms. A trigger during a reading, a trigger held past the end of the reading, and a trigger given while hold is released each show that no extra reading is granted.

// File: rtl/hts_pkg.sv
package hts_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_READ  = 2'd2
    } phase_e;
endpackage

// File: rtl/hts_trig_qual.sv
// Synchronises the external trigger and qualifies its width.
module hts_trig_qual #(
    parameter int unsigned MIN_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_n,
    output logic accept
);
    localparam int unsigned CNT_W = (MIN_CYCLES < 2) ? 1 : $clog2(MIN_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_CYCLES - 1);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic [CNT_W-1:0] cnt;
        logic             fired;
    } tq_t;

    tq_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        accept  = 1'b0;
        st_d.s1 = trig_n;
        st_d.s2 = st_q.s1;
        if (st_q.s2) begin
            st_d.cnt   = '0;
            st_d.fired = 1'b0;
        end else if (!st_q.fired) begin
            if (st_q.cnt == LAST) begin
                accept     = 1'b1;
                st_d.fired = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b1, s2: 1'b1, cnt: '0, fired: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/hts_mz_edge.sv
// Edge detector for the engine phase signal.
module hts_mz_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic mz,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = mz;
        rise   = mz & ~prev_q;
        fall   = ~mz & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/hts_arm_fsm.sv
// Hold register and arm/reading sequence.
module hts_arm_fsm
    import hts_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hold_n,
    input  logic   accept,
    input  logic   mz_rise,
    input  logic   mz_fall,
    output phase_e phase,
    output logic   hold_act,
    output logic   sample_en
);
    typedef struct packed {
        logic   hold;
        phase_e ph;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.hold = ~hold_n;
        if (hold_n) begin
            st_d.ph = PH_IDLE;
        end else begin
            unique case (st_q.ph)
                PH_IDLE:  if (accept && st_q.hold) st_d.ph = PH_ARMED;
                PH_ARMED: if (mz_rise) st_d.ph = PH_READ;
                PH_READ:  if (mz_fall) st_d.ph = PH_IDLE;
                default:  st_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{hold: 1'b0, ph: PH_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase     = st_q.ph;
    assign hold_act  = st_q.hold;
    assign sample_en = ~st_q.hold | (st_q.ph != PH_IDLE);
endmodule

// File: rtl/hold_trig_seq.sv
module hold_trig_seq #(
    parameter int unsigned TRIG_MIN_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_n,
    input  logic trig_n,
    input  logic mz,
    output logic sample_en
);
    logic            accept;
    logic            mz_rise;
    logic            mz_fall;
    logic            hold_act;
    hts_pkg::phase_e phase;

    hts_trig_qual #(.MIN_CYCLES(TRIG_MIN_CYCLES)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_n (trig_n),
        .accept (accept)
    );

    hts_mz_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .mz    (mz),
        .rise  (mz_rise),
        .fall  (mz_fall)
    );

    hts_arm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_n    (hold_n),
        .accept    (accept),
        .mz_rise   (mz_rise),
        .mz_fall   (mz_fall),
        .phase     (phase),
        .hold_act  (hold_act),
        .sample_en (sample_en)
    );
endmodule

// File: rtl/hold_trig_seq_chk.sv
module hold_trig_seq_chk (
    input logic            clk,
    input logic            rst_n,
    input logic            hold_n,
    input logic            accept,
    input logic            mz_rise,
    input logic            mz_fall,
    input logic            hold_act,
    input hts_pkg::phase_e phase,
    input logic            sample_en
);
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_free: assert (sample_en);
        end
    end

    a_r2_free_run: assert property (@(posedge clk) disable iff (!rst_n)
        hold_n |=> sample_en);

    a_r3_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n && phase == hts_pkg::PH_IDLE && !accept) |=> !sample_en);

    a_r4_accept_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n && hold_act && accept && phase == hts_pkg::PH_IDLE)
        |=> (phase == hts_pkg::PH_ARMED && sample_en));

    a_r5_fall_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n && phase == hts_pkg::PH_ARMED && mz_fall) |=> sample_en);

    a_r5_rise_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n && phase == hts_pkg::PH_ARMED && mz_rise) |=> phase == hts_pkg::PH_READ);

    a_r6_end_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n && phase == hts_pkg::PH_READ && mz_fall) |=> !sample_en);

    a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n && phase == hts_pkg::PH_ARMED && accept && !mz_rise)
        |=> phase == hts_pkg::PH_ARMED);

    a_r9_free_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hold_act) |=> phase == hts_pkg::PH_IDLE);
endmodule

bind hold_trig_seq hold_trig_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_n    (hold_n),
    .accept    (accept),
    .mz_rise   (mz_rise),
    .mz_fall   (mz_fall),
    .hold_act  (hold_act),
    .phase     (phase),
    .sample_en (sample_en)
);

// File: tb/hold_trig_seq_tb_top.sv
module hold_trig_seq_tb_top;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n, hold_n, trig_n, mz;
    logic sample_en;
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    typedef struct {
        int    at;
        logic  val;
        string req;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hold_trig_seq #(.TRIG_MIN_CYCLES(N)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_n    (hold_n),
        .trig_n    (trig_n),
        .mz        (mz),
        .sample_en (sample_en)
    );

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: cycle %0d sample_en=%b expected %b", req, cyc, act, exp);
        end
    endtask

    task automatic push(int d, logic v, string r);
        sb.push_back('{cyc + d, v, r});
    endtask

    task automatic push_span(int from, int to, logic v, string r);
        for (int d = from; d <= to; d++) push(d, v, r);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expected items due in the current cycle.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                check(sb[i].req, sample_en, sb[i].val);
                sb.delete(i);
            end
        end
    end

    initial begin
        rst_n = 1'b0; hold_n = 1'b1; trig_n = 1'b1; mz = 1'b0;
        step(3);
        check("R1", sample_en, 1'b1);
        rst_n = 1'b1;
        step(1);

        // R2: free run with mz toggling
        push_span(1, 6, 1'b1, "R2");
        for (int k = 0; k < 6; k++) begin step(1); mz = ~mz; end
        mz = 1'b0;
        step(2);

        // R3: enter hold, mz toggles, no trigger
        hold_n = 1'b0;
        push_span(1, 8, 1'b0, "R3");
        for (int k = 0; k < 6; k++) begin step(1); mz = ~mz; end
        mz = 1'b1;
        step(3);

        // R4: pulse one cycle short is ignored
        trig_n = 1'b0;
        step(N - 1);
        trig_n = 1'b1;
        push_span(1, N + 4, 1'b0, "R4");
        step(N + 5);

        // R4: pulse of exactly the minimum width arms
        trig_n = 1'b0;
        push(N + 1, 1'b0, "R4");
        push(N + 2, 1'b1, "R4");
        step(N);
        trig_n = 1'b1;
        step(3);

        // R5: falling mz while armed is ignored, rising starts reading
        mz = 1'b0;
        push_span(1, 3, 1'b1, "R5");
        step(3);
        mz = 1'b1;
        push_span(1, 3, 1'b1, "R5");
        step(3);

        // R8: trigger during reading is ignored; R6: end of reading disarms
        trig_n = 1'b0;
        step(N + 2);
        trig_n = 1'b1;
        step(3);
        check("R8", sample_en, 1'b1);
        mz = 1'b0;
        push(1, 1'b0, "R6");
        push_span(2, N + 4, 1'b0, "R8");
        step(N + 5);

        // R7: one long pulse gives one reading only
        trig_n = 1'b0;
        push(N + 2, 1'b1, "R7");
        step(N + 3);
        mz = 1'b1;
        step(2);
        mz = 1'b0;
        push(1, 1'b0, "R6");
        push_span(2, N + 6, 1'b0, "R7");
        step(N + 7);
        trig_n = 1'b1;
        step(2);

        // R9: trigger while hold released is ignored after hold returns
        hold_n = 1'b1;
        push(1, 1'b1, "R2");
        step(1);
        trig_n = 1'b0;
        step(N + 3);
        trig_n = 1'b1;
        step(2);
        hold_n = 1'b0;
        push_span(1, N + 3, 1'b0, "R9");
        step(N + 4);

        // R2: release returns to continuous sampling next clock
        hold_n = 1'b1;
        push_span(1, 3, 1'b1, "R2");
        step(4);

        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        done = 1'b1;
    end

    initial begin
        for (int k = 0; k < 5000 && !done; k++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: done=0 expected 1");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule